// File: doc/BRIEF.md
# Dual-Socket PC Card Bus Sequencer

This block turns a single request into a correctly timed card-bus cycle on one of two PC Card / CompactFlash sockets. A request gives the address space (common memory, attribute memory or I/O), the direction, the width (byte or 16-bit word), the target socket, the address and the write data. The sequencer then runs three phases:

- **Setup:** address, card enables, register-space select and socket select are driven ahead of the strobe.
- **Strobe:** exactly one of the four strobes is held low. The card can stretch this phase with its wait input.
- **Hold:** the address, enables and selects stay valid after the strobe is released.

The lengths of the setup, minimum-strobe and hold phases come from configuration inputs. The block also handles cards with an 8-bit data path:

- In byte-only mode the high enable is never used, and word requests become two byte cycles.
- A 16-bit I/O request to a card that does not signal 16-bit I/O capability during setup is split into two byte cycles, low byte first.

When the last hold phase ends, the block pulses a completion flag and presents the read data with the byte right-aligned. A new request is taken only while the block is idle.

Top module: `pccard_seq`

## Requirements
- R1: The register-space select `card_reg_n` is low during every non-idle cycle of an attribute (space code 1) or I/O (space code 2) access, and high for common memory (space code 0) and while idle. It and `card_addr` stay stable while a strobe is low.
- R2: Common-memory and attribute reads pulse only `card_oe_n`, and such writes pulse only `card_we_n`.
- R3: I/O reads pulse only `card_ior_n`, and I/O writes pulse only `card_iow_n`.
- R4: At most one of the four strobes is low in any cycle, and `card_sock` equals the socket bit of the request being served.
- R5: While `card_wait_n` is low during a strobe, the strobe is extended. A strobe lasts max(max(cfg_strobe,1), W+1) cycles when the card holds wait low for its first W strobe cycles.
- R6: Enables are asserted for max(cfg_setup,1) cycles before the first strobe and for max(cfg_hold,1) cycles after the last one. Between the two strobes of a split access there are max(cfg_hold,1)+max(cfg_setup,1) cycles.
- R7: A word request that is not split asserts both enables during its single strobe, with address bit 0 forced to 0, and drives the whole write word.
- R8: In 16-bit mode (cfg_byte_mode=0), a byte request asserts only `card_ce_lo_n` for an even address and only `card_ce_hi_n` for an odd one. Address bit 0 is passed through unchanged.
- R9: In byte-only mode (cfg_byte_mode=1), `card_ce_hi_n` is never asserted. A byte request uses `card_ce_lo_n` with address bit 0 equal to the request's bit 0.
- R10: A 16-bit I/O request in 16-bit mode, with `card_io16_n` high in the last setup cycle, becomes two byte strobes on the low enable with address bit 0 = 0 and then 1. The read result is {second byte, first byte}.
- R11: A word request in byte-only mode always becomes two low-enable byte strobes, address bit 0 = 0 then 1.
- R12: For any byte strobe, the write byte is driven on both data lanes: req_wdata[7:0], or req_wdata[15:8] for the second half of a split. A byte read returns its byte in rdata[7:0] with rdata[15:8] = 0; the byte is taken from the high lane only in the R8 odd case.
- R13: After reset all strobes, enables and the register select are high, `req_ready` is 1 and `done` is 0. A request is taken only while `req_ready` is 1. `done` is high for exactly one cycle after the final hold, with `rdata` valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken when req_ready is high |
| req_ready | output | 1 | Block idle and able to take a request |
| req_space | input | 2 | 0 common memory, 1 attribute, 2 I/O |
| req_write | input | 1 | 1 write, 0 read |
| req_wide | input | 1 | 1 word access, 0 byte access |
| req_sock | input | 1 | Target socket |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 16 | Write data (byte in bits 7:0) |
| cfg_byte_mode | input | 1 | 1 = card has an 8-bit data path only |
| cfg_setup | input | CFG_W | Setup cycles before the strobe (0 acts as 1) |
| cfg_strobe | input | CFG_W | Minimum strobe cycles (0 acts as 1) |
| cfg_hold | input | CFG_W | Hold cycles after the strobe (0 acts as 1) |
| card_wait_n | input | 1 | Card wait, low extends the strobe |
| card_io16_n | input | 1 | Card 16-bit I/O indication, low = 16-bit capable |
| card_rdata | input | 16 | Card read data |
| card_addr | output | ADDR_W | Card address |
| card_wdata | output | 16 | Card write data |
| card_reg_n | output | 1 | Register-space select, active low |
| card_oe_n | output | 1 | Memory read strobe, active low |
| card_we_n | output | 1 | Memory write strobe, active low |
| card_ior_n | output | 1 | I/O read strobe, active low |
| card_iow_n | output | 1 | I/O write strobe, active low |
| card_ce_lo_n | output | 1 | Low-byte card enable, active low |
| card_ce_hi_n | output | 1 | High-byte card enable, active low |
| card_sock | output | 1 | Socket select |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Read result, valid with done |

## Verification
Random requests mix all three spaces, both directions and widths, even and odd addresses, both modes, both states of the 16-bit I/O indication, phase lengths 0 to 3 and card wait counts 0 to 3. Cycle by cycle, the bench rebuilds each access: the number of strobes, their type, enables, address bit 0, lane data and phase lengths.

- **Wait counts below and above the minimum strobe length** tell apart a strobe that merely meets its minimum from one the card has stretched.
- **Odd addresses in both modes** separate high-lane from low-lane byte steering.
- **Word I/O with and without the 16-bit indication** separates a single word cycle from a two-byte split.

Directed cases add zero and maximum phase settings and long waits.

// File: rtl/pccard_pkg.sv
package pccard_pkg;

    typedef enum logic [1:0] {
        SP_COMMON = 2'd0,
        SP_ATTR   = 2'd1,
        SP_IO     = 2'd2
    } space_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SETUP,
        ST_STROBE,
        ST_HOLD
    } phase_e;

    typedef struct packed {
        logic oe;
        logic we;
        logic ior;
        logic iow;
    } strobe_t;

    typedef struct packed {
        logic [1:0]  space;
        logic        write;
        logic        wide;
        logic        sock;
        logic        byte_mode;
        logic [15:0] wdata;
    } txn_t;

    function automatic logic is_io(input logic [1:0] sp);
        return sp[1];
    endfunction

    function automatic strobe_t strobe_sel(input logic [1:0] sp, input logic wr);
        strobe_t s;
        s.oe  = !is_io(sp) && !wr;
        s.we  = !is_io(sp) &&  wr;
        s.ior =  is_io(sp) && !wr;
        s.iow =  is_io(sp) &&  wr;
        return s;
    endfunction

endpackage

// File: rtl/pccard_timer.sv
module pccard_timer #(
    parameter int CFG_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic [CFG_W-1:0] limit,
    output logic             expired
);
    logic [CFG_W-1:0] cnt;

    // a limit of zero behaves like one
    assign expired = ({1'b0, cnt} + 1'b1) >= {1'b0, limit};

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt <= '0;
        end else if (!expired) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/pccard_lane.sv
module pccard_lane (
    input  logic        phase_wide,
    input  logic        byte_mode,
    input  logic        split,
    input  logic        second,
    input  logic        addr0,
    input  logic [15:0] wdata,
    input  logic [15:0] card_rdata,
    output logic        ce_lo,
    output logic        ce_hi,
    output logic        a0,
    output logic [15:0] lane_wdata,
    output logic [7:0]  rd_byte
);
    logic       hi_lane;
    logic [7:0] wbyte;

    always_comb begin
        hi_lane = !phase_wide && !byte_mode && !split && addr0;
        wbyte   = second ? wdata[15:8] : wdata[7:0];
        if (phase_wide) begin
            ce_lo      = 1'b1;
            ce_hi      = 1'b1;
            a0         = 1'b0;
            lane_wdata = wdata;
        end else begin
            ce_lo      = !hi_lane;
            ce_hi      = hi_lane;
            a0         = split ? second : addr0;
            lane_wdata = {wbyte, wbyte};
        end
        rd_byte = hi_lane ? card_rdata[15:8] : card_rdata[7:0];
    end
endmodule

// File: rtl/pccard_seq.sv
module pccard_seq
    import pccard_pkg::*;
#(
    parameter int ADDR_W = 26,
    parameter int CFG_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_space,
    input  logic              req_write,
    input  logic              req_wide,
    input  logic              req_sock,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [15:0]       req_wdata,
    input  logic              cfg_byte_mode,
    input  logic [CFG_W-1:0]  cfg_setup,
    input  logic [CFG_W-1:0]  cfg_strobe,
    input  logic [CFG_W-1:0]  cfg_hold,
    input  logic              card_wait_n,
    input  logic              card_io16_n,
    input  logic [15:0]       card_rdata,
    output logic [ADDR_W-1:0] card_addr,
    output logic [15:0]       card_wdata,
    output logic              card_reg_n,
    output logic              card_oe_n,
    output logic              card_we_n,
    output logic              card_ior_n,
    output logic              card_iow_n,
    output logic              card_ce_lo_n,
    output logic              card_ce_hi_n,
    output logic              card_sock,
    output logic              done,
    output logic [15:0]       rdata
);
    phase_e             state, state_nx;
    txn_t               txn;
    logic [ADDR_W-1:0]  addr_q;
    logic               split_q, second_q;
    logic               expired, accept, split_now, phase_wide, active;
    logic [CFG_W-1:0]   limit;
    logic               ce_lo, ce_hi, a0;
    logic [7:0]         rd_byte;
    strobe_t            stb;

    assign accept     = req_valid && (state == ST_IDLE);
    assign phase_wide = txn.wide && !split_q;
    assign active     = (state != ST_IDLE);
    assign split_now  = is_io(txn.space) && txn.wide && !txn.byte_mode
                        && card_io16_n && !second_q;

    always_comb begin
        case (state)
            ST_SETUP:  limit = cfg_setup;
            ST_STROBE: limit = cfg_strobe;
            default:   limit = cfg_hold;
        endcase
    end

    always_comb begin
        state_nx = state;
        case (state)
            ST_IDLE:   if (accept) state_nx = ST_SETUP;
            ST_SETUP:  if (expired) state_nx = ST_STROBE;
            ST_STROBE: if (expired && card_wait_n) state_nx = ST_HOLD;
            ST_HOLD:   if (expired) state_nx = (split_q && !second_q) ? ST_SETUP : ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    pccard_timer #(.CFG_W(CFG_W)) i_timer (
        .clk     (clk),
        .rst     (rst),
        .restart (state_nx != state),
        .limit   (limit),
        .expired (expired)
    );

    pccard_lane i_lane (
        .phase_wide (phase_wide),
        .byte_mode  (txn.byte_mode),
        .split      (split_q),
        .second     (second_q),
        .addr0      (addr_q[0]),
        .wdata      (txn.wdata),
        .card_rdata (card_rdata),
        .ce_lo      (ce_lo),
        .ce_hi      (ce_hi),
        .a0         (a0),
        .lane_wdata (card_wdata),
        .rd_byte    (rd_byte)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            txn      <= '0;
            addr_q   <= '0;
            split_q  <= 1'b0;
            second_q <= 1'b0;
            done     <= 1'b0;
            rdata    <= '0;
        end else begin
            state <= state_nx;
            done  <= 1'b0;
            if (accept) begin
                txn.space     <= req_space;
                txn.write     <= req_write;
                txn.wide      <= req_wide;
                txn.sock      <= req_sock;
                txn.byte_mode <= cfg_byte_mode;
                txn.wdata     <= req_wdata;
                addr_q        <= req_addr;
                split_q       <= req_wide && cfg_byte_mode;
                second_q      <= 1'b0;
            end
            if (state == ST_SETUP && state_nx == ST_STROBE && split_now) begin
                split_q <= 1'b1;
            end
            if (state == ST_STROBE && state_nx == ST_HOLD) begin
                if (phase_wide)    rdata       <= card_rdata;
                else if (second_q) rdata[15:8] <= rd_byte;
                else               rdata       <= {8'h00, rd_byte};
            end
            if (state == ST_HOLD && state_nx == ST_SETUP) second_q <= 1'b1;
            if (state == ST_HOLD && state_nx == ST_IDLE)  done     <= 1'b1;
        end
    end

    assign stb          = strobe_sel(txn.space, txn.write);
    assign req_ready    = (state == ST_IDLE);
    assign card_addr    = {addr_q[ADDR_W-1:1], a0};
    assign card_reg_n   = !(active && (txn.space != SP_COMMON));
    assign card_oe_n    = !(state == ST_STROBE && stb.oe);
    assign card_we_n    = !(state == ST_STROBE && stb.we);
    assign card_ior_n   = !(state == ST_STROBE && stb.ior);
    assign card_iow_n   = !(state == ST_STROBE && stb.iow);
    assign card_ce_lo_n = !(active && ce_lo);
    assign card_ce_hi_n = !(active && ce_hi);
    assign card_sock    = txn.sock;

    logic strobing;
    assign strobing = !(card_oe_n && card_we_n && card_ior_n && card_iow_n);

    // R4
    single_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        $countones({~card_oe_n, ~card_we_n, ~card_ior_n, ~card_iow_n}) <= 1);

    // R1
    strobe_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (strobing && $past(strobing)) |-> ($stable(card_reg_n) && $stable(card_addr)));

    // R5
    wait_extend_chk: assert property (@(posedge clk) disable iff (rst)
        (strobing && !card_wait_n) |=> strobing);

    // R9
    byte_mode_hi_chk: assert property (@(posedge clk) disable iff (rst)
        (active && txn.byte_mode) |-> card_ce_hi_n);

    // R13
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
endmodule

// File: tb/test_pccard_seq.sv
module test_pccard_seq;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_space = '0;
    logic        req_write = 1'b0, req_wide = 1'b0, req_sock = 1'b0;
    logic [25:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        cfg_byte_mode = 1'b0;
    logic [3:0]  cfg_setup = '0, cfg_strobe = '0, cfg_hold = '0;
    logic        card_wait_n = 1'b1, card_io16_n = 1'b0;
    logic [15:0] card_rdata = '0;
    logic [25:0] card_addr;
    logic [15:0] card_wdata, rdata;
    logic        card_reg_n, card_oe_n, card_we_n, card_ior_n, card_iow_n;
    logic        card_ce_lo_n, card_ce_hi_n, card_sock, done;

    int total = 0;
    int bad   = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    pccard_seq i_pccard_seq (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_space(req_space), .req_write(req_write), .req_wide(req_wide),
        .req_sock(req_sock), .req_addr(req_addr), .req_wdata(req_wdata),
        .cfg_byte_mode(cfg_byte_mode), .cfg_setup(cfg_setup),
        .cfg_strobe(cfg_strobe), .cfg_hold(cfg_hold),
        .card_wait_n(card_wait_n), .card_io16_n(card_io16_n),
        .card_rdata(card_rdata), .card_addr(card_addr), .card_wdata(card_wdata),
        .card_reg_n(card_reg_n), .card_oe_n(card_oe_n), .card_we_n(card_we_n),
        .card_ior_n(card_ior_n), .card_iow_n(card_iow_n),
        .card_ce_lo_n(card_ce_lo_n), .card_ce_hi_n(card_ce_hi_n),
        .card_sock(card_sock), .done(done), .rdata(rdata)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            bad   = bad + 1;
            total = total + 1;
            $display("FAIL watchdog: actual=%0d expected=<150000 cycles", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    function automatic logic [15:0] card_model(input logic [25:0] a);
        return {a[7:0] ^ 8'h5A, a[8:1] ^ 8'hC3};
    endfunction

    function automatic int at_least1(input int v);
        return (v == 0) ? 1 : v;
    endfunction

    task automatic chk(input string tag, input string what, input longint act, input longint exp);
        total = total + 1;
        if (act != exp) begin
            bad = bad + 1;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic run_txn(input logic [1:0] sp, input logic wr, input logic wide,
                           input logic sock, input logic [25:0] ad, input logic [15:0] wd,
                           input logic bm, input logic io16n,
                           input int s, input int st, input int h, input int w);
        int pre = 0, gap = 0, after = 0, np = 0, k = 0, iter = 0, multi = 0;
        int slen [2];
        int kind [2];
        logic [25:0] paddr [2];
        logic pce_lo [2], pce_hi [2], preg [2], psock [2];
        logic [15:0] pwd [2];
        logic prev = 1'b0, strb, hung = 1'b0;
        int nph, exp_kind, cnt_low, idx;
        string etag, ktag;
        logic hi;
        logic [15:0] m0, m1, exp_r;
        for (int i = 0; i < 2; i++) begin
            slen[i] = 0; kind[i] = 0; paddr[i] = '0; pce_lo[i] = 1'b1;
            pce_hi[i] = 1'b1; preg[i] = 1'b1; psock[i] = 1'b0; pwd[i] = '0;
        end
        @(negedge clk);
        req_space = sp; req_write = wr; req_wide = wide; req_sock = sock;
        req_addr = ad; req_wdata = wd; cfg_byte_mode = bm; card_io16_n = io16n;
        cfg_setup = s[3:0]; cfg_strobe = st[3:0]; cfg_hold = h[3:0];
        card_wait_n = 1'b1;
        chk("R13", "ready before request", req_ready, 1);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        while (1) begin
            card_rdata = card_model(card_addr);
            if (done) break;
            cnt_low = (!card_oe_n) + (!card_we_n) + (!card_ior_n) + (!card_iow_n);
            if (cnt_low > 1) multi = 1;
            strb = (cnt_low != 0);
            if (strb) begin
                if (!prev) begin
                    if (np < 2) begin
                        kind[np]   = !card_oe_n ? 0 : !card_we_n ? 1 : !card_ior_n ? 2 : 3;
                        paddr[np]  = card_addr;
                        pce_lo[np] = card_ce_lo_n;
                        pce_hi[np] = card_ce_hi_n;
                        preg[np]   = card_reg_n;
                        psock[np]  = card_sock;
                        pwd[np]    = card_wdata;
                    end
                    if (np == 1) gap = after;
                    after = 0;
                    np = np + 1;
                    k = 0;
                end
                k = k + 1;
                if (np <= 2) slen[np-1] = slen[np-1] + 1;
                card_wait_n = (k > w);
            end else begin
                card_wait_n = 1'b1;
                if (!card_ce_lo_n || !card_ce_hi_n) begin
                    if (np == 0) pre = pre + 1;
                    else after = after + 1;
                end
            end
            prev = strb;
            iter = iter + 1;
            if (iter > 400) begin hung = 1'b1; break; end
            @(negedge clk);
        end
        chk("R13", "done reached", hung, 0);
        if (hung) return;

        nph      = (wide && (bm || (sp == 2'd2 && io16n))) ? 2 : 1;
        exp_kind = (sp == 2'd2) ? (wr ? 3 : 2) : (wr ? 1 : 0);
        ktag     = (sp == 2'd2) ? "R3" : "R2";
        etag     = (nph == 2) ? (bm ? "R11" : "R10") : (wide ? "R7" : (bm ? "R9" : "R8"));
        hi       = !wide && !bm && ad[0];

        chk(etag, "strobe count", np, nph);
        chk("R4", "strobe overlap", multi, 0);
        chk("R6", "setup cycles", pre, at_least1(s));
        chk("R6", "hold cycles", after, at_least1(h));
        if (nph == 2) chk("R6", "gap cycles", gap, at_least1(h) + at_least1(s));
        if (np == nph) begin
            for (int p = 0; p < nph; p++) begin
                idx = p;
                chk(ktag, "strobe type", kind[idx], exp_kind);
                chk("R1", "reg select", preg[idx], (sp == 2'd0) ? 1 : 0);
                chk("R4", "socket", psock[idx], sock);
                chk("R5", "strobe length", slen[idx],
                    (at_least1(st) > w + 1) ? at_least1(st) : w + 1);
                if (nph == 2) begin
                    chk(etag, "ce_lo", pce_lo[idx], 0);
                    chk(etag, "ce_hi", pce_hi[idx], 1);
                    chk(etag, "address", paddr[idx], {ad[25:1], p[0]});
                    if (wr) chk("R12", "split write lanes", pwd[idx],
                                p == 0 ? {wd[7:0], wd[7:0]} : {wd[15:8], wd[15:8]});
                end else if (wide) begin
                    chk(etag, "ce_lo", pce_lo[idx], 0);
                    chk(etag, "ce_hi", pce_hi[idx], 0);
                    chk(etag, "address", paddr[idx], {ad[25:1], 1'b0});
                    if (wr) chk("R7", "word write data", pwd[idx], wd);
                end else begin
                    chk(etag, "ce_lo", pce_lo[idx], hi ? 1 : 0);
                    chk(etag, "ce_hi", pce_hi[idx], hi ? 0 : 1);
                    chk(etag, "address", paddr[idx], ad);
                    if (wr) chk("R12", "byte write lanes", pwd[idx], {wd[7:0], wd[7:0]});
                end
            end
        end
        if (!wr) begin
            m0 = card_model({ad[25:1], 1'b0});
            m1 = card_model({ad[25:1], 1'b1});
            if (nph == 2)  exp_r = {m1[7:0], m0[7:0]};
            else if (wide) exp_r = m0;
            else begin
                m0 = card_model(ad);
                exp_r = hi ? {8'h00, m0[15:8]} : {8'h00, m0[7:0]};
            end
            chk((nph == 2) ? etag : "R12", "read data", rdata, exp_r);
        end
        @(negedge clk);
        chk("R13", "done single cycle", done, 0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R13 reset state
        chk("R13", "ready after reset", req_ready, 1);
        chk("R13", "done after reset", done, 0);
        chk("R13", "strobes idle", {card_oe_n, card_we_n, card_ior_n, card_iow_n}, 4'hF);
        chk("R13", "enables idle", {card_ce_lo_n, card_ce_hi_n, card_reg_n}, 3'h7);

        // directed corners
        run_txn(2'd2, 1'b0, 1'b1, 1'b1, 26'h0123_456, 16'h0, 1'b0, 1'b1, 1, 2, 1, 0); // R10 read split
        run_txn(2'd2, 1'b1, 1'b1, 1'b0, 26'h0000_101, 16'hBEEF, 1'b0, 1'b1, 2, 1, 2, 1); // R10 write split
        run_txn(2'd2, 1'b0, 1'b1, 1'b0, 26'h0000_222, 16'h0, 1'b0, 1'b0, 1, 1, 1, 0); // R7 io word
        run_txn(2'd0, 1'b0, 1'b1, 1'b1, 26'h0000_333, 16'h0, 1'b1, 1'b0, 0, 0, 0, 0); // R11 byte mode word
        run_txn(2'd0, 1'b0, 1'b0, 1'b0, 26'h0000_045, 16'h0, 1'b0, 1'b0, 1, 1, 1, 0); // R8 odd high lane
        run_txn(2'd1, 1'b1, 1'b0, 1'b1, 26'h0000_047, 16'h12C4, 1'b1, 1'b0, 1, 1, 1, 0); // R9 odd byte mode
        run_txn(2'd1, 1'b0, 1'b0, 1'b0, 26'h0000_047, 16'h0, 1'b1, 1'b0, 1, 1, 1, 0); // R9 read low lane
        run_txn(2'd0, 1'b1, 1'b1, 1'b0, 26'h0000_010, 16'hA55A, 1'b0, 1'b0, 0, 1, 0, 5); // R5 long wait
        run_txn(2'd1, 1'b0, 1'b1, 1'b1, 26'h0000_011, 16'h0, 1'b0, 1'b0, 15, 15, 15, 2); // R6 max phases
        run_txn(2'd2, 1'b1, 1'b0, 1'b1, 26'h0000_013, 16'h0077, 1'b0, 1'b1, 0, 4, 0, 1); // R3 byte io

        for (int n = 0; n < 200; n++) begin
            run_txn(2'($urandom_range(0, 2)), 1'($urandom), 1'($urandom), 1'($urandom),
                    26'($urandom), 16'($urandom), 1'($urandom), 1'($urandom),
                    $urandom_range(0, 3), $urandom_range(0, 3), $urandom_range(0, 3),
                    $urandom_range(0, 3));
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule